// File: doc/BRIEF.md
# Local Interrupt Controller Mode and Reset Unit

This unit holds the two mode-control bits of a local interrupt controller (an enable bit and an extended-mode bit) and the reset-time contents of the controller's architectural registers. Software reaches it through one synchronous port that shares a single address between a write strobe and a read strobe. Every write to the mode bits is checked against the legal transitions. An illegal write changes nothing and raises a one-cycle fault pulse.

The remaining registers are plain storage. Each one loads its own defined value on reset, and the bank keeps and returns whatever is later written to it. The controller ID is captured from a hardware input while reset is held. It reads back in the layout that matches the current mode. Prioritisation, delivery and timer counting belong to neighbouring blocks.

Top module: `intc_mode_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mode becomes enabled/legacy. The mode register at address 0 then reads 0x1, with bit 0 = enable and bit 1 = extended.
- R2: The stored mode is never enable=0 with extended=1 (mode value 2'b10).
- R3: A write to address 0 whose wdata[1:0] is 2'b10 leaves the mode unchanged and causes a fault pulse.
- R4: A write to address 0 from extended (2'b11) to legacy (2'b01) is rejected with a fault. Leaving extended mode through disabled (2'b00) is allowed. Every other transition between the values 00, 01 and 11 is accepted without a fault.
- R5: `fault` is high for exactly one cycle, in the cycle after the offending access, and stays low after legal accesses.
- R6: `rdata` and `rd_valid` present the addressed register one cycle after `rd_en`. `rd_valid` is low in the cycle after a cycle without `rd_en`.
- R7: `hw_id` is captured while reset is held. Address 1 reads {id[7:0], 24'h0} when extended=0 and the full 32-bit ID when extended=1. Writes to address 1 have no effect.
- R8: After reset these registers read zero: task priority (3), logical destination (4), command (7), divide configuration (8), timer initial count (9), timer current count (10), self-IPI (11), request words (32..39), in-service words (40..47) and trigger-mode words (48..55). Each of them stores and returns any 32-bit value written to it.
- R9: After reset each local vector table entry (addresses 16..21) reads 0x00010000, which is only its mask bit 16 set. Each entry is writable.
- R10: After reset the spurious-vector register (6) reads 0x000000FF and destination format (5) reads 0xFFFFFFFF. Version (2) always reads the VERSION_VAL parameter, 0x00050014 by default, and ignores writes.
- R11: In extended mode a read of destination format returns 0 and causes a fault pulse. A write to it in extended mode is ignored, so the stored value is still there after returning to legacy mode.
- R12: Addresses outside the map read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; ID is captured while low |
| hw_id | input | 32 | Hardware controller ID |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | rdata holds a fresh read result |
| fault | output | 1 | One-cycle pulse after an illegal access |
| mode_en | output | 1 | Current enable bit |
| mode_ext | output | 1 | Current extended-mode bit |

## Verification
Every result of this unit is due exactly one clock after the access that causes it. A mode update, a fault pulse and read data all appear in the cycle after the strobe. The bench drives a strobe on a falling edge, clears it on the next falling edge and samples the outputs at that same moment. At that point exactly one rising edge has passed. Fault checks on legal accesses therefore see the pulse slot itself, and a separate idle-cycle sample confirms the pulse has ended.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // Mode encoding: bit 0 = enable, bit 1 = extended
   typedef enum logic [1:0] {
      MODE_OFF = 2'b00,
      MODE_LEG = 2'b01,
      MODE_BAD = 2'b10,
      MODE_EXT = 2'b11
   } mode_e;

   localparam int A_MODE = 0;
   localparam int A_ID   = 1;
   localparam int A_VER  = 2;
   localparam int A_TPR  = 3;
   localparam int A_LDST = 4;
   localparam int A_DFMT = 5;
   localparam int A_SPUR = 6;
   localparam int A_CMD  = 7;
   localparam int A_DIV  = 8;
   localparam int A_TINI = 9;
   localparam int A_TCUR = 10;
   localparam int A_SELF = 11;
   localparam int A_LVT  = 16;
   localparam int A_VEC  = 32;

endpackage

// File: rtl/intc_mode_ctl.sv
module intc_mode_ctl
   import intc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_mode,
   input  logic [1:0] wr_val,
   output mode_e      mode_q,
   output logic       bad_wr
);

   mode_e target;
   logic  illegal;

   always_comb begin
      target  = mode_e'(wr_val);
      illegal = (target == MODE_BAD) ||
                ((mode_q == MODE_EXT) && (target == MODE_LEG));
      bad_wr  = wr_mode && illegal;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= MODE_LEG;
      else if (wr_mode && !illegal)
         mode_q <= target;
   end

   // R1
   reset_mode_chk: assert property (@(posedge clk)
      !rst_n |=> (mode_q == MODE_LEG));

   // R2
   no_bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != MODE_BAD);

   // R3
   bad_target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && wr_val == 2'b10) |=> $stable(mode_q));

   // R4
   ext_to_leg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && mode_q == MODE_EXT && wr_val == 2'b01) |=> (mode_q == MODE_EXT));

endmodule

// File: rtl/intc_reg_bank.sv
module intc_reg_bank
   import intc_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 32,
   parameter int NUM_LVT   = 6,
   parameter int VEC_WORDS = 8,
   parameter int MASK_BIT  = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word
);

   localparam int NREG    = 1 << ADDR_W;
   localparam int LVT_END = A_LVT + NUM_LVT;
   localparam int VEC_END = A_VEC + 3 * VEC_WORDS;

   function automatic bit is_stor(int i);
      return (i >= A_TPR && i <= A_SELF) ||
             (i >= A_LVT && i < LVT_END) ||
             (i >= A_VEC && i < VEC_END);
   endfunction

   function automatic logic [DATA_W-1:0] rst_val(int i);
      if (i == A_DFMT)
         return '1;
      else if (i == A_SPUR)
         return DATA_W'(8'hFF);
      else if (i >= A_LVT && i < LVT_END)
         return DATA_W'(1) << MASK_BIT;
      else
         return '0;
   endfunction

   logic [DATA_W-1:0] words [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      if (is_stor(i)) begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= rst_val(i);
            else if (wr_en && wr_addr == ADDR_W'(i))
               q <= wdata;
         end
         assign words[i] = q;

         // R8 R9 R10
         slot_reset_chk: assert property (@(posedge clk)
            !rst_n |=> (q == rst_val(i)));
      end else begin : g_hole
         assign words[i] = '0;
      end
   end

   assign rd_word = words[rd_addr];

endmodule

// File: rtl/intc_read_path.sv
module intc_read_path
   import intc_pkg::*;
#(
   parameter int          ADDR_W      = 6,
   parameter int          DATA_W      = 32,
   parameter int          ID_W        = 32,
   parameter int          LID_W       = 8,
   parameter logic [31:0] VERSION_VAL = 32'h0005_0014
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  mode_e             mode,
   input  logic [ID_W-1:0]   id_q,
   input  logic [DATA_W-1:0] bank_word,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_valid,
   output logic              bad_rd
);

   logic [DATA_W-1:0] id_view;
   logic [DATA_W-1:0] rd_next;
   logic              dfmt_hit;

   always_comb begin
      if (mode[1])
         id_view = DATA_W'(id_q);
      else
         id_view = {id_q[LID_W-1:0], {(DATA_W-LID_W){1'b0}}};
   end

   assign dfmt_hit = (rd_addr == ADDR_W'(A_DFMT)) && (mode == MODE_EXT);
   assign bad_rd   = rd_en && dfmt_hit;

   always_comb begin
      if (rd_addr == ADDR_W'(A_MODE))
         rd_next = DATA_W'(mode);
      else if (rd_addr == ADDR_W'(A_ID))
         rd_next = id_view;
      else if (rd_addr == ADDR_W'(A_VER))
         rd_next = DATA_W'(VERSION_VAL);
      else if (dfmt_hit)
         rd_next = '0;
      else
         rd_next = bank_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en)
            rdata <= rd_next;
      end
   end

   // R6
   rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R6
   rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R11
   dfmt_ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADDR_W'(A_DFMT) && mode == MODE_EXT) |=> (rdata == '0));

endmodule

// File: rtl/intc_mode_unit.sv
module intc_mode_unit
   import intc_pkg::*;
#(
   parameter int          ADDR_W      = 6,
   parameter int          DATA_W      = 32,
   parameter int          ID_W        = 32,
   parameter int          LID_W       = 8,
   parameter int          NUM_LVT     = 6,
   parameter int          VEC_WORDS   = 8,
   parameter int          MASK_BIT    = 16,
   parameter logic [31:0] VERSION_VAL = 32'h0005_0014
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   hw_id,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_valid,
   output logic              fault,
   output logic              mode_en,
   output logic              mode_ext
);

   localparam int NREG = 1 << ADDR_W;

   if (ADDR_W < 6)
      $error("ADDR_W must be at least 6");
   if (NUM_LVT < 1 || NUM_LVT > A_VEC - A_LVT)
      $error("NUM_LVT out of range");
   if (A_VEC + 3 * VEC_WORDS > NREG)
      $error("VEC_WORDS does not fit the address space");
   if (MASK_BIT >= DATA_W || ID_W > DATA_W || LID_W > ID_W || DATA_W < 8)
      $error("field widths inconsistent");

   mode_e             mode_q;
   logic              bad_wr;
   logic              bad_rd;
   logic              wr_mode;
   logic              wr_bank;
   logic [ID_W-1:0]   id_q;
   logic [DATA_W-1:0] bank_word;

   assign wr_mode  = wr_en && (addr == ADDR_W'(A_MODE));
   assign wr_bank  = wr_en && !((addr == ADDR_W'(A_DFMT)) && (mode_q == MODE_EXT));
   assign mode_en  = mode_q[0];
   assign mode_ext = mode_q[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q  <= hw_id;
         fault <= 1'b0;
      end else begin
         fault <= bad_wr || bad_rd;
      end
   end

   intc_mode_ctl u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_mode (wr_mode),
      .wr_val  (wdata[1:0]),
      .mode_q  (mode_q),
      .bad_wr  (bad_wr)
   );

   intc_reg_bank #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_LVT   (NUM_LVT),
      .VEC_WORDS (VEC_WORDS),
      .MASK_BIT  (MASK_BIT)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_bank),
      .wr_addr (addr),
      .wdata   (wdata),
      .rd_addr (addr),
      .rd_word (bank_word)
   );

   intc_read_path #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .ID_W        (ID_W),
      .LID_W       (LID_W),
      .VERSION_VAL (VERSION_VAL)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .rd_addr   (addr),
      .mode      (mode_q),
      .id_q      (id_q),
      .bank_word (bank_word),
      .rdata     (rdata),
      .rd_valid  (rd_valid),
      .bad_rd    (bad_rd)
   );

   // R3
   bad_target_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_MODE) && wdata[1:0] == 2'b10) |=> fault);

   // R5
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(wr_en || rd_en));

   // R7
   id_ext_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(A_ID) && mode_q == MODE_EXT) |=> (rdata == DATA_W'(id_q)));

endmodule

// File: tb/intc_mode_unit_tb.sv
module intc_mode_unit_tb;

   localparam logic [31:0] ID  = 32'hC3A5_7E42;
   localparam logic [31:0] VER = 32'h0005_0014;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] hw_id = ID;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rd_valid, fault, mode_en, mode_ext;

   int nvec = 0;
   int nbad = 0;
   logic [1:0]  cur_mode;
   logic [31:0] got;
   logic        got_f;

   always #5 clk = ~clk;

   intc_mode_unit u_dut (
      .clk(clk), .rst_n(rst_n), .hw_id(hw_id), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
      .fault(fault), .mode_en(mode_en), .mode_ext(mode_ext)
   );

   function automatic bit is_stor(int a);
      return (a >= 3 && a <= 11) || (a >= 16 && a <= 21) || (a >= 32 && a <= 55);
   endfunction

   function automatic logic [31:0] rst_exp(int a);
      if (a == 0) return 32'h1;
      if (a == 1) return {ID[7:0], 24'h0};
      if (a == 2) return VER;
      if (a == 5) return 32'hFFFF_FFFF;
      if (a == 6) return 32'h0000_00FF;
      if (a >= 16 && a <= 21) return 32'h0001_0000;
      return 32'h0;
   endfunction

   function automatic logic [31:0] pat(int a);
      return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   endtask

   task automatic do_wr(int a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 6'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      got_f = fault;
   endtask

   task automatic do_rd(int a);
      @(negedge clk);
      rd_en = 1'b1; addr = 6'(a);
      @(negedge clk);
      rd_en = 1'b0;
      got   = rdata;
      got_f = fault;
      chk("R6 rd_valid", 32'(rd_valid), 32'h1);
   endtask

   task automatic set_mode(logic [1:0] s);
      do_wr(0, 32'h0);
      if (s != 2'b00) do_wr(0, 32'(s));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      hw_id = 32'h0;
      @(negedge clk);
      chk("R1 mode pins", {30'h0, mode_ext, mode_en}, 32'h1);
      chk("R5 fault idle", 32'(fault), 32'h0);
      chk("R6 rd_valid idle", 32'(rd_valid), 32'h0);

      // reset values over the whole address space
      for (int a = 0; a < 64; a++) begin
         do_rd(a);
         if (a == 0)                   chk("R1 mode reg", got, rst_exp(a));
         else if (a == 1)              chk("R7 id legacy", got, rst_exp(a));
         else if (a == 2 || a == 5 || a == 6) chk("R10 reset", got, rst_exp(a));
         else if (a >= 16 && a <= 21)  chk("R9 lvt reset", got, rst_exp(a));
         else if (is_stor(a))          chk("R8 zero reset", got, rst_exp(a));
         else                          chk("R12 hole", got, rst_exp(a));
         chk("R5 no fault on read", 32'(got_f), 32'h0);
      end

      // write a pattern everywhere except the mode register
      for (int a = 1; a < 64; a++) do_wr(a, pat(a));
      for (int a = 1; a < 64; a++) begin
         do_rd(a);
         if (is_stor(a))     chk((a >= 16 && a <= 21) ? "R9 lvt store" : "R8 store", got, pat(a));
         else if (a == 1)    chk("R7 id write ignored", got, rst_exp(a));
         else if (a == 2)    chk("R10 version ro", got, VER);
         else                chk("R12 hole write", got, 32'h0);
      end

      // mode transition sweep
      cur_mode = 2'b01;
      foreach (cur_mode[k]) ; // no-op
      for (int si = 0; si < 3; si++) begin
         for (int t = 0; t < 4; t++) begin
            logic [1:0] s;
            logic       bad;
            logic [1:0] exp_m;
            s = (si == 0) ? 2'b00 : (si == 1) ? 2'b01 : 2'b11;
            set_mode(s);
            bad   = (t == 2) || (s == 2'b11 && t == 1);
            exp_m = bad ? s : 2'(t);
            do_wr(0, 32'(t) | 32'hFFFF_FFF0);
            if (t == 2) chk("R3 bad target fault", 32'(got_f), 32'h1);
            else        chk("R4 transition fault", 32'(got_f), 32'(bad));
            @(negedge clk);
            chk("R5 pulse ends", 32'(fault), 32'h0);
            do_rd(0);
            if (t == 2) chk("R2 R3 mode kept", got, 32'(exp_m));
            else        chk("R4 mode after", got, 32'(exp_m));
            chk("R2 pins", {30'h0, mode_ext, mode_en}, 32'(exp_m));
         end
      end

      // ID layouts
      set_mode(2'b00);
      do_rd(1);
      chk("R7 id disabled", got, {ID[7:0], 24'h0});
      set_mode(2'b11);
      do_rd(1);
      chk("R7 id extended", got, ID);

      // destination format in extended mode
      do_wr(5, 32'h1234_5678);
      chk("R11 write no fault", 32'(got_f), 32'h0);
      do_rd(5);
      chk("R11 read zero", got, 32'h0);
      chk("R11 read fault", 32'(got_f), 32'h1);
      @(negedge clk);
      chk("R5 pulse ends", 32'(fault), 32'h0);
      set_mode(2'b01);
      do_rd(5);
      chk("R11 write ignored", got, pat(5));
      chk("R11 legacy no fault", 32'(got_f), 32'h0);

      // reset again restores defaults
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      do_rd(0);
      chk("R1 mode after reset", got, 32'h1);
      do_rd(16);
      chk("R9 lvt after reset", got, 32'h0001_0000);

      finish_run();
   end

endmodule